// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the digital counting core of a frequency synthesizer loop. A fast input clock is divided by a programmable total ratio built from three settings: a prescaler base P, a main count N and a swallow count A. The resulting comparison pulse `fp` fires once every P*N + A input cycles. The ratio is not produced by one wide modulo counter. A small prescaler counter divides by either P or P+1. A swallow counter holds the prescaler at P+1 for the first A prescaler periods of every divide cycle. A main counter ends the divide cycle after N prescaler periods. On a second, slower oscillator clock, a reference divider produces the pulse `fr` once every R oscillator cycles. The loop compares the two pulses outside this block.

Settings are written with a load strobe and checked before they are accepted. An accepted feedback setting is held pending and takes over only when the current divide cycle ends, so no shortened or stretched cycle is ever produced. A rejected setting raises an error flag and leaves the ratio in use untouched. The sleep input freezes both dividers at the start of a cycle, so that after wake-up the first pulses come at a known time.

Top module: `pswallow_synth`

## Requirements
- R1: After reset the feedback setting is N=5, A=0, band 0 and the reference ratio is 5. `fp`, `fr`, `cfg_err` and `ref_err` are low. With `cfg_band`=0 the prescaler base is 64, and `fp` repeats every 64*N + A cycles of `fin_clk`.
- R2: With `cfg_band`=1 the prescaler base is 128, and `fp` repeats every 128*N + A cycles of `fin_clk`.
- R3: The swallow count adds exactly A cycles for every A from 0 to N-1, including A=0 and the largest value A=127 with N=128.
- R4: `fp` is high for exactly one `fin_clk` cycle per divide cycle.
- R5: A `cfg_load` with N < 5 or with A >= N sets `cfg_err` in the next cycle, and the ratio in use does not change.
- R6: A `cfg_load` with a legal setting clears `cfg_err` in the next cycle.
- R7: An accepted feedback setting is first used for the divide cycle that starts after the next `fp`. The divide cycle already in progress completes with the old ratio.
- R8: While `sleep` is high, `fp` stays low and the feedback counters wait at the start of a cycle. A setting loaded during sleep is the one used after wake-up. The first `fp` comes exactly P*N + A `fin_clk` cycles after the first rising edge at which `sleep` is low.
- R9: `fr` repeats every R cycles of `osc_clk`, and each pulse is one `osc_clk` cycle wide.
- R10: A `ref_load` with R < 5 sets `ref_err` and keeps the previous R. A legal `ref_load` clears `ref_err`, and the new R takes effect at the next `fr` boundary.
- R11: Two `osc_clk` cycles after `sleep` rises, `fr` stops and stays low while `sleep` is held.
- R12: Built with the band select removed (DUAL=0), the prescaler base is fixed at PRE_LO. With PRE_LO=16, N=291 and A=7 the period is 4663 cycles, and a reference ratio of 384 gives a 384-cycle `fr` period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fin_clk | input | 1 | Fast divided clock (feedback domain) |
| osc_clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sleep | input | 1 | Power-save hold; freezes both dividers at cycle start |
| cfg_load | input | 1 | Load strobe for the feedback setting (fin_clk domain) |
| cfg_band | input | 1 | Prescaler base select: 0 gives PRE_LO, 1 gives PRE_HI |
| cfg_n | input | NW | Main counter value N |
| cfg_a | input | AW | Swallow counter value A |
| cfg_err | output | 1 | Last feedback load was rejected |
| fp | output | 1 | One-cycle comparison pulse per feedback divide cycle |
| ref_load | input | 1 | Load strobe for the reference ratio (osc_clk domain) |
| ref_r | input | RW | Reference ratio R |
| ref_err | output | 1 | Last reference load was rejected |
| fr | output | 1 | One-cycle reference pulse every R osc_clk cycles |

## Verification
The bench goes after the edges of the swallow range. A=0 catches a design that always swallows one period. A=N-1 with the largest A catches a swallow counter that wraps or one that stops one period early, and either error shows as a period off by exactly A or by one. It loads a new ratio right after a pulse and measures two intervals. A design that applies settings at once would show a runt first interval instead of the old ratio. Illegal settings are sent between legal ones to expose a design that still lets a bad N or A reach the counters. The first pulse after sleep is timed to the exact cycle, which exposes a prescaler left mid-count or a setting loaded during sleep that is dropped.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Prescaler modulus control: divide by the base, or by the base plus one.
  typedef enum logic {
    PRE_NORMAL = 1'b0,
    PRE_PLUS1  = 1'b1
  } mod_e;

  // Terminal value of the prescaler count for a given base and modulus.
  function automatic int term_count(input int base, input logic plus_one);
    return base - 1 + (plus_one ? 1 : 0);
  endfunction

  // Total input cycles in one feedback divide cycle.
  function automatic int cycle_len(input int p, input int n, input int a);
    return p * n + a;
  endfunction

  // A feedback setting is usable when N reaches the floor and A stays below N.
  function automatic logic fb_legal(input int n, input int a, input int n_min);
    return (n >= n_min) && (a >= 0) && (a < n);
  endfunction

  // A reference ratio is usable when it reaches the floor.
  function automatic logic ref_legal(input int r, input int r_min);
    return r >= r_min;
  endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int PRE_LO = 64,
  parameter int PRE_HI = 128,
  parameter int DUAL   = 1,
  parameter int PCW    = 8
)(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic band,
  input  mod_e mod,
  output logic tick
);

  logic [PCW-1:0] pc;
  logic [PCW-1:0] base;
  logic [PCW-1:0] last;

  generate
    if (DUAL != 0) begin : g_dual
      assign base = band ? PCW'(PRE_HI) : PCW'(PRE_LO);
    end else begin : g_fixed
      assign base = PCW'(PRE_LO);
    end
  endgenerate

  always_comb begin
    last = PCW'(term_count(int'(base), mod == PRE_PLUS1));
  end

  assign tick = !hold && (pc == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (hold || tick) begin
      pc <= '0;
    end else begin
      pc <= pc + PCW'(1);
    end
  end

endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr
  import psd_pkg::*;
#(
  parameter int NW    = 11,
  parameter int AW    = 7,
  parameter int RST_N = 5,
  parameter int RST_A = 0
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          tick,
  input  logic [NW-1:0] nxt_n,
  input  logic [AW-1:0] nxt_a,
  output mod_e          mod,
  output logic          boundary,
  output logic [AW-1:0] sc_val
);

  logic [NW-1:0] nc;
  logic [AW-1:0] sc;

  // Prescaler runs long while swallow periods remain.
  assign mod      = (sc != '0) ? PRE_PLUS1 : PRE_NORMAL;
  assign boundary = tick && (nc == NW'(1));
  assign sc_val   = sc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nc <= NW'(RST_N);
      sc <= AW'(RST_A);
    end else if (hold || boundary) begin
      nc <= nxt_n;
      sc <= nxt_a;
    end else if (tick) begin
      nc <= nc - NW'(1);
      if (sc != '0) begin
        sc <= sc - AW'(1);
      end
    end
  end

endmodule

// File: rtl/psd_fb_cfg.sv
module psd_fb_cfg
  import psd_pkg::*;
#(
  parameter int NW    = 11,
  parameter int AW    = 7,
  parameter int N_MIN = 5,
  parameter int RST_N = 5,
  parameter int RST_A = 0
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply,
  input  logic          load,
  input  logic          in_band,
  input  logic [NW-1:0] in_n,
  input  logic [AW-1:0] in_a,
  output logic          ok,
  output logic          err,
  output logic          act_band,
  output logic [NW-1:0] act_n,
  output logic [AW-1:0] act_a,
  output logic          nxt_band,
  output logic [NW-1:0] nxt_n,
  output logic [AW-1:0] nxt_a
);

  typedef struct packed {
    logic          band;
    logic [NW-1:0] n;
    logic [AW-1:0] a;
  } fb_cfg_t;

  localparam fb_cfg_t CFG_RST = '{band: 1'b0, n: NW'(RST_N), a: AW'(RST_A)};

  fb_cfg_t act, pend, nxt, incoming;
  logic    pend_v;

  assign incoming = '{band: in_band, n: in_n, a: in_a};
  assign ok       = fb_legal(int'(in_n), int'(in_a), N_MIN);
  assign nxt      = pend_v ? pend : act;

  assign act_band = act.band;
  assign act_n    = act.n;
  assign act_a    = act.a;
  assign nxt_band = nxt.band;
  assign nxt_n    = nxt.n;
  assign nxt_a    = nxt.a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= CFG_RST;
      pend   <= CFG_RST;
      pend_v <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (apply) begin
        act    <= nxt;
        pend_v <= 1'b0;
      end
      // A load in the same cycle as an apply stays pending for the next one.
      if (load) begin
        if (ok) begin
          pend   <= incoming;
          pend_v <= 1'b1;
          err    <= 1'b0;
        end else begin
          err    <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/psd_refdiv.sv
module psd_refdiv
  import psd_pkg::*;
#(
  parameter int RW    = 14,
  parameter int R_MIN = 5,
  parameter int RST_R = 5
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_async,
  input  logic          load,
  input  logic [RW-1:0] r_in,
  output logic          err,
  output logic          fr
);

  logic          slp_m, slp_q;
  logic [RW-1:0] rc, act_r, pend_r, nxt_r;
  logic          pend_v, ok, term, apply;

  assign ok    = ref_legal(int'(r_in), R_MIN);
  assign term  = !slp_q && (rc == RW'(1));
  assign apply = term || slp_q;
  assign nxt_r = pend_v ? pend_r : act_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_m  <= 1'b0;
      slp_q  <= 1'b0;
      rc     <= RW'(RST_R);
      act_r  <= RW'(RST_R);
      pend_r <= RW'(RST_R);
      pend_v <= 1'b0;
      err    <= 1'b0;
      fr     <= 1'b0;
    end else begin
      slp_m <= sleep_async;
      slp_q <= slp_m;
      fr    <= term;
      if (apply) begin
        act_r  <= nxt_r;
        rc     <= nxt_r;
        pend_v <= 1'b0;
      end else begin
        rc <= rc - RW'(1);
      end
      if (load) begin
        if (ok) begin
          pend_r <= r_in;
          pend_v <= 1'b1;
          err    <= 1'b0;
        end else begin
          err    <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pswallow_synth.sv
module pswallow_synth
  import psd_pkg::*;
#(
  parameter int NW     = 11,
  parameter int AW     = 7,
  parameter int RW     = 14,
  parameter int PRE_LO = 64,
  parameter int PRE_HI = 128,
  parameter int DUAL   = 1,
  parameter int N_MIN  = 5,
  parameter int R_MIN  = 5,
  parameter int RST_N  = 5,
  parameter int RST_A  = 0,
  parameter int RST_R  = 5
)(
  input  logic          fin_clk,
  input  logic          osc_clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          cfg_load,
  input  logic          cfg_band,
  input  logic [NW-1:0] cfg_n,
  input  logic [AW-1:0] cfg_a,
  output logic          cfg_err,
  output logic          fp,
  input  logic          ref_load,
  input  logic [RW-1:0] ref_r,
  output logic          ref_err,
  output logic          fr
);

  localparam int PMAX = (PRE_HI > PRE_LO) ? PRE_HI : PRE_LO;
  localparam int PCW  = $clog2(PMAX + 2);

  // Named internal events, visible to the bound checker.
  logic          evt_boundary;
  logic          pre_tick;
  mod_e          mod_ctl;
  logic [AW-1:0] sc_val;
  logic          cfg_ok;
  logic          act_band, nxt_band;
  logic [NW-1:0] act_n, nxt_n;
  logic [AW-1:0] act_a, nxt_a;
  logic          cfg_apply;

  assign cfg_apply = evt_boundary || sleep;

  psd_fb_cfg #(
    .NW(NW), .AW(AW), .N_MIN(N_MIN), .RST_N(RST_N), .RST_A(RST_A)
  ) u_cfg (
    .clk      (fin_clk),
    .rst_n    (rst_n),
    .apply    (cfg_apply),
    .load     (cfg_load),
    .in_band  (cfg_band),
    .in_n     (cfg_n),
    .in_a     (cfg_a),
    .ok       (cfg_ok),
    .err      (cfg_err),
    .act_band (act_band),
    .act_n    (act_n),
    .act_a    (act_a),
    .nxt_band (nxt_band),
    .nxt_n    (nxt_n),
    .nxt_a    (nxt_a)
  );

  psd_prescaler #(
    .PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DUAL(DUAL), .PCW(PCW)
  ) u_pre (
    .clk   (fin_clk),
    .rst_n (rst_n),
    .hold  (sleep),
    .band  (act_band),
    .mod   (mod_ctl),
    .tick  (pre_tick)
  );

  psd_swallow_ctr #(
    .NW(NW), .AW(AW), .RST_N(RST_N), .RST_A(RST_A)
  ) u_swc (
    .clk      (fin_clk),
    .rst_n    (rst_n),
    .hold     (sleep),
    .tick     (pre_tick),
    .nxt_n    (nxt_n),
    .nxt_a    (nxt_a),
    .mod      (mod_ctl),
    .boundary (evt_boundary),
    .sc_val   (sc_val)
  );

  always_ff @(posedge fin_clk or negedge rst_n) begin
    if (!rst_n) begin
      fp <= 1'b0;
    end else begin
      fp <= evt_boundary && !sleep;
    end
  end

  psd_refdiv #(
    .RW(RW), .R_MIN(R_MIN), .RST_R(RST_R)
  ) u_ref (
    .clk         (osc_clk),
    .rst_n       (rst_n),
    .sleep_async (sleep),
    .load        (ref_load),
    .r_in        (ref_r),
    .err         (ref_err),
    .fr          (fr)
  );

endmodule

// File: rtl/psd_checker.sv
module psd_checker
  import psd_pkg::*;
#(
  parameter int NW     = 11,
  parameter int AW     = 7,
  parameter int PRE_LO = 64,
  parameter int PRE_HI = 128,
  parameter int DUAL   = 1,
  parameter int N_MIN  = 5
)(
  input logic          fin_clk,
  input logic          osc_clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          cfg_load,
  input logic          cfg_ok,
  input logic          cfg_err,
  input logic          fp,
  input logic          evt_boundary,
  input logic          act_band,
  input logic [NW-1:0] act_n,
  input logic [AW-1:0] act_a,
  input logic [AW-1:0] sc_val,
  input logic          fr
);

  // Interval counter between fp pulses; the expected length is latched
  // from the setting that starts each divide cycle.
  int   gap;
  int   exp_len;
  logic armed;
  int   p_now;

  assign p_now = (DUAL != 0 && act_band) ? PRE_HI : PRE_LO;

  always_ff @(posedge fin_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= 0;
      exp_len <= 0;
      armed   <= 1'b0;
    end else if (sleep) begin
      gap   <= 0;
      armed <= 1'b0;
    end else if (fp) begin
      gap     <= 1;
      exp_len <= cycle_len(p_now, int'(act_n), int'(act_a));
      armed   <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  // R1 and R2: interval matches P*N+A for the setting in force
  assert_cycle_len_R1: assert property (@(posedge fin_clk) disable iff (!rst_n)
    (fp && armed) |-> (gap == exp_len))
    else $error("cycle length mismatch");

  assert_fp_single_R4: assert property (@(posedge fin_clk) disable iff (!rst_n)
    fp |=> !fp)
    else $error("fp wider than one cycle");

  assert_swallow_reload_R3: assert property (@(posedge fin_clk) disable iff (!rst_n)
    evt_boundary |=> (sc_val == act_a))
    else $error("swallow count not reloaded with active A");

  assert_reject_R5: assert property (@(posedge fin_clk) disable iff (!rst_n)
    (cfg_load && !cfg_ok) |=> cfg_err)
    else $error("illegal setting not flagged");

  assert_legal_active_R5: assert property (@(posedge fin_clk) disable iff (!rst_n)
    (int'(act_n) >= N_MIN) && (act_a < AW'(act_n)) || (act_n > NW'((1 << AW) - 1)))
    else $error("illegal setting reached the counters");

  assert_accept_R6: assert property (@(posedge fin_clk) disable iff (!rst_n)
    (cfg_load && cfg_ok) |=> !cfg_err)
    else $error("legal setting left error raised");

  assert_ratio_hold_R7: assert property (@(posedge fin_clk) disable iff (!rst_n)
    !(evt_boundary || sleep) |=> ($stable(act_n) && $stable(act_a) && $stable(act_band)))
    else $error("ratio changed inside a divide cycle");

  assert_quiet_sleep_R8: assert property (@(posedge fin_clk) disable iff (!rst_n)
    sleep |=> !fp)
    else $error("fp during sleep");

  assert_fr_single_R9: assert property (@(posedge osc_clk) disable iff (!rst_n)
    fr |=> !fr)
    else $error("fr wider than one cycle");

endmodule

bind pswallow_synth psd_checker #(
  .NW(NW), .AW(AW), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DUAL(DUAL), .N_MIN(N_MIN)
) u_chk (
  .fin_clk      (fin_clk),
  .osc_clk      (osc_clk),
  .rst_n        (rst_n),
  .sleep        (sleep),
  .cfg_load     (cfg_load),
  .cfg_ok       (cfg_ok),
  .cfg_err      (cfg_err),
  .fp           (fp),
  .evt_boundary (evt_boundary),
  .act_band     (act_band),
  .act_n        (act_n),
  .act_a        (act_a),
  .sc_val       (sc_val),
  .fr           (fr)
);

// File: tb/sim_pswallow_synth.sv
module sim_pswallow_synth;

  logic fin_clk = 1'b0;
  logic osc_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic sleep   = 1'b0;

  always #2.5 fin_clk = ~fin_clk;   // 200 MHz
  always #12.5 osc_clk = ~osc_clk;  // 40 MHz

  // Dual-band instance
  logic        cfg_load = 1'b0, cfg_band = 1'b0;
  logic [10:0] cfg_n = '0;
  logic [6:0]  cfg_a = '0;
  logic        cfg_err, fp;
  logic        ref_load = 1'b0;
  logic [13:0] ref_r = '0;
  logic        ref_err, fr;

  // Fixed-band instance
  logic        c1_load = 1'b0;
  logic [10:0] c1_n = '0;
  logic [6:0]  c1_a = '0;
  logic        c1_err, fp1;
  logic        r1_load = 1'b0;
  logic [13:0] r1_r = '0;
  logic        r1_err, fr1;

  pswallow_synth u0 (
    .fin_clk(fin_clk), .osc_clk(osc_clk), .rst_n(rst_n), .sleep(sleep),
    .cfg_load(cfg_load), .cfg_band(cfg_band), .cfg_n(cfg_n), .cfg_a(cfg_a),
    .cfg_err(cfg_err), .fp(fp),
    .ref_load(ref_load), .ref_r(ref_r), .ref_err(ref_err), .fr(fr)
  );

  pswallow_synth #(.DUAL(0), .PRE_LO(16)) u1 (
    .fin_clk(fin_clk), .osc_clk(osc_clk), .rst_n(rst_n), .sleep(sleep),
    .cfg_load(c1_load), .cfg_band(1'b0), .cfg_n(c1_n), .cfg_a(c1_a),
    .cfg_err(c1_err), .fp(fp1),
    .ref_load(r1_load), .ref_r(r1_r), .ref_err(r1_err), .fr(fr1)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic check(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic fp_now(input bit u);
    return u ? fp1 : fp;
  endfunction

  function automatic logic fr_now(input bit u);
    return u ? fr1 : fr;
  endfunction

  // Expected ratios restated from the requirements.
  function automatic int want_fb(input int p, input int n, input int a);
    int total;
    total = a;
    for (int k = 0; k < n; k++) total += p;
    return total;
  endfunction

  task automatic wait_fp(input bit u);
    do @(negedge fin_clk); while (!fp_now(u));
  endtask

  task automatic gap_fp(input bit u, output int g);
    g = 0;
    do begin @(negedge fin_clk); g++; end while (!fp_now(u));
  endtask

  task automatic wait_fr(input bit u);
    do @(negedge osc_clk); while (!fr_now(u));
  endtask

  task automatic gap_fr(input bit u, output int g);
    g = 0;
    do begin @(negedge osc_clk); g++; end while (!fr_now(u));
  endtask

  // Load a feedback setting immediately (at the current negedge).
  task automatic load_now(input bit u, input bit band, input int n, input int a);
    if (u) begin
      c1_n = 11'(n); c1_a = 7'(a); c1_load = 1'b1;
      @(negedge fin_clk);
      c1_load = 1'b0;
    end else begin
      cfg_band = band; cfg_n = 11'(n); cfg_a = 7'(a); cfg_load = 1'b1;
      @(negedge fin_clk);
      cfg_load = 1'b0;
    end
  endtask

  // Load just after a pulse, then skip to the first cycle that uses it.
  task automatic load_fb(input bit u, input bit band, input int n, input int a);
    wait_fp(u);
    load_now(u, band, n, a);
    wait_fp(u);
  endtask

  task automatic load_ref(input bit u, input int r);
    wait_fr(u);
    if (u) begin
      r1_r = 14'(r); r1_load = 1'b1;
      @(negedge osc_clk);
      r1_load = 1'b0;
    end else begin
      ref_r = 14'(r); ref_load = 1'b1;
      @(negedge osc_clk);
      ref_load = 1'b0;
    end
  endtask

  task automatic t_reset;
    int g;
    @(negedge fin_clk);
    check("R1", "fp after reset", int'(fp), 0);
    check("R1", "cfg_err after reset", int'(cfg_err), 0);
    check("R1", "fr after reset", int'(fr), 0);
    check("R1", "ref_err after reset", int'(ref_err), 0);
    wait_fp(0);
    gap_fp(0, g);
    check("R1", "default period", g, want_fb(64, 5, 0));
  endtask

  task automatic t_low_band;
    int g;
    load_fb(0, 1'b0, 7, 3);
    gap_fp(0, g);
    check("R1", "band0 N7 A3", g, want_fb(64, 7, 3));
    @(negedge fin_clk);
    check("R4", "fp width", int'(fp), 0);
  endtask

  task automatic t_high_band;
    int g;
    load_fb(0, 1'b1, 5, 4);
    gap_fp(0, g);
    check("R2", "band1 N5 A4", g, want_fb(128, 5, 4));
  endtask

  task automatic t_swallow_edges;
    int g;
    load_fb(0, 1'b1, 5, 0);
    gap_fp(0, g);
    check("R3", "A=0", g, want_fb(128, 5, 0));
    load_fb(0, 1'b0, 128, 127);
    gap_fp(0, g);
    check("R3", "A=127 N=128", g, want_fb(64, 128, 127));
  endtask

  task automatic t_bad_n;
    int g;
    load_fb(0, 1'b0, 8, 2);
    wait_fp(0);
    load_now(0, 1'b0, 4, 0);
    check("R5", "err on N<5", int'(cfg_err), 1);
    wait_fp(0);
    gap_fp(0, g);
    check("R5", "ratio kept after N<5", g, want_fb(64, 8, 2));
  endtask

  task automatic t_bad_a;
    int g;
    wait_fp(0);
    load_now(0, 1'b1, 6, 6);
    check("R5", "err on A>=N", int'(cfg_err), 1);
    wait_fp(0);
    gap_fp(0, g);
    check("R5", "ratio kept after A>=N", g, want_fb(64, 8, 2));
    wait_fp(0);
    load_now(0, 1'b0, 9, 8);
    check("R6", "err cleared", int'(cfg_err), 0);
    wait_fp(0);
    gap_fp(0, g);
    check("R6", "new legal ratio", g, want_fb(64, 9, 8));
  endtask

  task automatic t_boundary;
    int g;
    wait_fp(0);
    // Count from this pulse, including the load cycles.
    cfg_band = 1'b1; cfg_n = 11'd6; cfg_a = 7'd5; cfg_load = 1'b1;
    g = 0;
    @(negedge fin_clk); g++;
    cfg_load = 1'b0;
    while (!fp) begin @(negedge fin_clk); g++; end
    check("R7", "cycle in progress keeps old ratio", g, want_fb(64, 9, 8));
    gap_fp(0, g);
    check("R7", "next cycle uses new ratio", g, want_fb(128, 6, 5));
  endtask

  task automatic t_sleep;
    int hits_fp, hits_fr, k;
    @(negedge fin_clk);
    sleep = 1'b1;
    hits_fp = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge fin_clk);
      if (fp) hits_fp++;
    end
    check("R8", "fp pulses while asleep", hits_fp, 0);
    hits_fr = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge osc_clk);
      if (fr) hits_fr++;
    end
    check("R11", "fr pulses while asleep", hits_fr, 0);
    @(negedge fin_clk);
    load_now(0, 1'b0, 5, 2);
    repeat (3) @(negedge fin_clk);
    sleep = 1'b0;
    k = 0;
    do begin @(negedge fin_clk); k++; end while (!fp);
    check("R8", "first fp after wake", k, want_fb(64, 5, 2));
  endtask

  task automatic t_ref;
    int g;
    wait_fr(0);
    gap_fr(0, g);
    check("R9", "default ref period", g, 5);
    load_ref(0, 1000);
    wait_fr(0);
    gap_fr(0, g);
    check("R9", "ref period 1000", g, 1000);
    @(negedge osc_clk);
    check("R9", "fr width", int'(fr), 0);
  endtask

  task automatic t_ref_bad;
    int g;
    load_ref(0, 4);
    check("R10", "ref_err on R<5", int'(ref_err), 1);
    wait_fr(0);
    gap_fr(0, g);
    check("R10", "ref ratio kept", g, 1000);
    load_ref(0, 37);
    check("R10", "ref_err cleared", int'(ref_err), 0);
    wait_fr(0);
    gap_fr(0, g);
    check("R10", "ref ratio 37", g, 37);
  endtask

  task automatic t_fixed_band;
    int g;
    load_fb(1, 1'b0, 291, 7);
    gap_fp(1, g);
    check("R12", "fixed base 16 N291 A7", g, want_fb(16, 291, 7));
    load_ref(1, 384);
    wait_fr(1);
    gap_fr(1, g);
    check("R12", "fixed instance ref 384", g, 384);
  endtask

  initial begin
    repeat (4) @(negedge fin_clk);
    rst_n = 1'b1;
    t_reset();
    t_low_band();
    t_high_band();
    t_swallow_edges();
    t_bad_n();
    t_bad_a();
    t_boundary();
    t_sleep();
    t_ref();
    t_ref_bad();
    t_fixed_band();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge fin_clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule